// File: doc/BRIEF.md
# Indexed Pixel Colour Lookup with Hardware Cursor Overlay

This block sits in a display pixel stream. Each accepted pixel arrives as an 8-bit colour index together with its raster column and row. The block turns it into a 24-bit RGB value using a 256-entry colour lookup table. On top of that, it can overlay a 64x64 hardware cursor. Frame timing and video memory fetch are handled elsewhere. The block only needs a valid strobe with coordinates, and it returns the coloured pixel a fixed number of cycles later, with the same coordinates.

The cursor shape is stored as 2-bit codes, eight pixels packed into each 16-bit word. Code 0 lets the underlying pixel show through. Codes 1 to 3 choose one of three cursor colours. The cursor position, a cursor-off control and a force-blank control are static inputs that are sampled with each pixel. The colour table, the cursor colours and the shape words are internal memories, loaded through one write port and cleared by reset.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, out_valid is low and all three memories read zero, so a pixel sent before any write comes out as RGB 0.
- R2: A pixel accepted with in_valid high in one cycle shows up with out_valid high exactly two rising edges later, with out_x and out_y equal to its in_x and in_y. With no input, out_valid stays low.
- R3: Outside the cursor, out_rgb is the colour table entry selected by in_index, in the form red[23:16], green[15:8], blue[7:0].
- R4: The cursor origin is column cur_pos[23:12] and row cur_pos[11:0]. A pixel is inside the cursor when both of its coordinates are at or beyond the origin and less than 64 past it.
- R5: Inside the cursor, with column offset dx and row offset dy, the shape word number is dy*8 + dx/8. The pixel code is the 2-bit field starting at bit 2*(dx mod 8) of that word.
- R6: Code 0 outputs the colour table entry for in_index. Codes 1, 2 and 3 output cursor colours 0, 1 and 2.
- R7: While cur_off is high, no pixel is treated as inside the cursor.
- R8: While force_blank is high, the output pixel is 0, whatever the index and the cursor.
- R9: The coordinate comparisons use unsigned 12-bit values and do not wrap. A cursor that runs past column or row 4095 is clipped and never reappears at low coordinates.
- R10: A write with wr_en high acts according to wr_sel. With 0, wr_data is written into colour table entry wr_addr[7:0]. With 1, wr_data is written into cursor colour wr_addr, but only when wr_addr is 0 to 2; any other address is ignored. With 2, wr_data[15:0] is written into shape word wr_addr. With 3, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Memory write strobe |
| wr_sel | input | 2 | Write target: 0 colour table, 1 cursor colours, 2 shape, 3 none |
| wr_addr | input | 9 | Write entry address |
| wr_data | input | 24 | Write data (RGB, or shape word in bits 15:0) |
| cur_pos | input | 24 | Cursor origin: column in 23:12, row in 11:0 |
| cur_off | input | 1 | Cursor disable |
| force_blank | input | 1 | Force black output |
| in_valid | input | 1 | Input pixel strobe |
| in_x | input | 12 | Input pixel column |
| in_y | input | 12 | Input pixel row |
| in_index | input | 8 | Input pixel colour index |
| out_valid | output | 1 | Output pixel strobe |
| out_x | output | 12 | Output pixel column |
| out_y | output | 12 | Output pixel row |
| out_rgb | output | 24 | Output pixel colour |

## Verification
Every pixel result (colour, coordinates and strobe) is due two rising edges after the edge that accepts the pixel. Cursor position and the two control bits are sampled on that first edge. The memories are read in the second cycle. The bench drives a pixel on a falling edge and removes the strobe on the next falling edge. At that point it checks that out_valid is still low, and it compares the full result on the falling edge after that. Memory writes and control changes are made only while no pixel is in flight, so the result the bench expects cannot depend on when a read happens inside the pipeline.

// File: rtl/curov_pkg.sv
package curov_pkg;
    typedef enum logic [1:0] {
        SEL_CLUT = 2'd0,
        SEL_CPAL = 2'd1,
        SEL_PAT  = 2'd2,
        SEL_NONE = 2'd3
    } wr_sel_e;
endpackage

// File: rtl/curov_store.sv
module curov_store #(
    parameter int DEPTH = 256,
    parameter int DW    = 24,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];
    logic          wr_ok;
    logic          rd_ok;

    generate
        if (DEPTH == (1 << AW)) begin : g_full
            assign wr_ok = we;
            assign rd_ok = 1'b1;
        end else begin : g_part
            assign wr_ok = we && (32'(waddr) < DEPTH);
            assign rd_ok = (32'(raddr) < DEPTH);
        end
    endgenerate

    always_comb begin
        mem_d = mem_q;
        if (wr_ok) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = rd_ok ? mem_q[raddr] : '0;
endmodule

// File: rtl/curov_hit.sv
module curov_hit #(
    parameter int COORD_W = 12,
    parameter int SIZE    = 64,
    parameter int WORD_W  = 16,
    parameter int PPW     = WORD_W / 2,
    parameter int OFF_W   = $clog2(SIZE),
    parameter int LANE_W  = $clog2(PPW),
    parameter int WIDX_W  = OFF_W + OFF_W - LANE_W
) (
    input  logic [COORD_W-1:0] px,
    input  logic [COORD_W-1:0] py,
    input  logic [COORD_W-1:0] cx,
    input  logic [COORD_W-1:0] cy,
    input  logic               off,
    output logic               hit,
    output logic [WIDX_W-1:0]  word_idx,
    output logic [LANE_W-1:0]  lane
);
    logic [COORD_W:0] dx_full;
    logic [COORD_W:0] dy_full;
    logic             in_x;
    logic             in_y;
    logic [OFF_W-1:0] dx;
    logic [OFF_W-1:0] dy;

    always_comb begin
        dx_full  = {1'b0, px} - {1'b0, cx};
        dy_full  = {1'b0, py} - {1'b0, cy};
        in_x     = !dx_full[COORD_W] && (dx_full < (COORD_W+1)'(SIZE));
        in_y     = !dy_full[COORD_W] && (dy_full < (COORD_W+1)'(SIZE));
        hit      = !off && in_x && in_y;
        dx       = dx_full[OFF_W-1:0];
        dy       = dy_full[OFF_W-1:0];
        word_idx = {dy, dx[OFF_W-1:LANE_W]};
        lane     = dx[LANE_W-1:0];
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
    parameter int COORD_W  = 12,
    parameter int IDX_W    = 8,
    parameter int CH_W     = 8,
    parameter int CUR_SIZE = 64,
    parameter int PAT_W    = 16,
    parameter int NCPAL    = 3,
    parameter int RGB_W    = 3 * CH_W,
    parameter int PPW      = PAT_W / 2,
    parameter int OFF_W    = $clog2(CUR_SIZE),
    parameter int LANE_W   = $clog2(PPW),
    parameter int PAT_AW   = OFF_W + OFF_W - LANE_W,
    parameter int PAT_DEPTH = 1 << PAT_AW,
    parameter int CLUT_DEPTH = 1 << IDX_W,
    parameter int CP_AW    = 2,
    parameter int WA_W     = (PAT_AW > IDX_W) ? PAT_AW : IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [WA_W-1:0]    wr_addr,
    input  logic [RGB_W-1:0]   wr_data,
    input  logic [2*COORD_W-1:0] cur_pos,
    input  logic               cur_off,
    input  logic               force_blank,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [IDX_W-1:0]   in_index,
    output logic               out_valid,
    output logic [COORD_W-1:0] out_x,
    output logic [COORD_W-1:0] out_y,
    output logic [RGB_W-1:0]   out_rgb
);
    import curov_pkg::*;

    typedef struct packed {
        logic               valid;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [IDX_W-1:0]   idx;
        logic [1:0]         code;
        logic               blank;
    } s1_t;

    typedef struct packed {
        logic               valid;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [RGB_W-1:0]   rgb;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } state_t;

    state_t st_d, st_q;

    wr_sel_e             sel;
    logic                hit;
    logic [PAT_AW-1:0]   word_idx;
    logic [LANE_W-1:0]   lane;
    logic [PAT_W-1:0]    pat_word;
    logic [RGB_W-1:0]    clut_rd;
    logic [RGB_W-1:0]    cpal_rd;
    logic [CP_AW-1:0]    cpal_ra;
    logic                cpal_addr_ok;

    assign sel          = wr_sel_e'(wr_sel);
    assign cpal_addr_ok = (wr_addr[WA_W-1:CP_AW] == '0);
    assign cpal_ra      = st_q.s1.code - 2'd1;

    curov_hit #(
        .COORD_W (COORD_W),
        .SIZE    (CUR_SIZE),
        .WORD_W  (PAT_W)
    ) u_hit (
        .px       (in_x),
        .py       (in_y),
        .cx       (cur_pos[2*COORD_W-1:COORD_W]),
        .cy       (cur_pos[COORD_W-1:0]),
        .off      (cur_off),
        .hit      (hit),
        .word_idx (word_idx),
        .lane     (lane)
    );

    curov_store #(.DEPTH(PAT_DEPTH), .DW(PAT_W), .AW(PAT_AW)) u_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && sel == SEL_PAT),
        .waddr (wr_addr[PAT_AW-1:0]),
        .wdata (wr_data[PAT_W-1:0]),
        .raddr (word_idx),
        .rdata (pat_word)
    );

    curov_store #(.DEPTH(CLUT_DEPTH), .DW(RGB_W), .AW(IDX_W)) u_clut (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && sel == SEL_CLUT),
        .waddr (wr_addr[IDX_W-1:0]),
        .wdata (wr_data),
        .raddr (st_q.s1.idx),
        .rdata (clut_rd)
    );

    curov_store #(.DEPTH(NCPAL), .DW(RGB_W), .AW(CP_AW)) u_cpal (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && sel == SEL_CPAL && cpal_addr_ok),
        .waddr (wr_addr[CP_AW-1:0]),
        .wdata (wr_data),
        .raddr (cpal_ra),
        .rdata (cpal_rd)
    );

    always_comb begin
        st_d = st_q;
        // stage 1: sample pixel and controls, resolve cursor code
        st_d.s1.valid = in_valid;
        st_d.s1.x     = in_x;
        st_d.s1.y     = in_y;
        st_d.s1.idx   = in_index;
        st_d.s1.blank = force_blank;
        st_d.s1.code  = hit ? pat_word[2*lane +: 2] : 2'd0;
        // stage 2: colour lookup and blanking
        st_d.s2.valid = st_q.s1.valid;
        st_d.s2.x     = st_q.s1.x;
        st_d.s2.y     = st_q.s1.y;
        if (st_q.s1.blank) begin
            st_d.s2.rgb = '0;
        end else if (st_q.s1.code != 2'd0) begin
            st_d.s2.rgb = cpal_rd;
        end else begin
            st_d.s2.rgb = clut_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.s2.valid;
    assign out_x     = st_q.s2.x;
    assign out_y     = st_q.s2.y;
    assign out_rgb   = st_q.s2.rgb;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1.valid |=> out_valid) else $error("valid lost"); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.s1.valid |=> !out_valid) else $error("spurious valid"); // R2
    AST_COORD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 (out_x == $past(in_x, 2) && out_y == $past(in_y, 2)))
        else $error("coordinates changed"); // R2
    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && force_blank) |=> ##1 (out_rgb == '0))
        else $error("blank not black"); // R8
    AST_OFF_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_off) |=> (st_q.s1.code == 2'd0))
        else $error("cursor shown while off"); // R7
    AST_LEFT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_x < cur_pos[2*COORD_W-1:COORD_W]) |=> (st_q.s1.code == 2'd0))
        else $error("cursor left of origin"); // R4
endmodule

// File: tb/cursor_overlay_tb.sv
`timescale 1ns/1ps
module cursor_overlay_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [8:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [23:0] cur_pos = '0;
    logic        cur_off = 1'b0;
    logic        force_blank = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_x = '0;
    logic [11:0] in_y = '0;
    logic [7:0]  in_index = '0;
    logic        out_valid;
    logic [11:0] out_x;
    logic [11:0] out_y;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;

    logic [23:0] m_clut [256];
    logic [23:0] m_cpal [3];
    logic [15:0] m_pat  [512];

    always #5 clk = ~clk;

    cursor_overlay u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .cur_pos(cur_pos),
        .cur_off(cur_off), .force_blank(force_blank), .in_valid(in_valid),
        .in_x(in_x), .in_y(in_y), .in_index(in_index), .out_valid(out_valid),
        .out_x(out_x), .out_y(out_y), .out_rgb(out_rgb)
    );

    function automatic logic [23:0] model(int x, int y, int idx);
        int cx, cy, dx, dy;
        logic [15:0] w;
        int code;
        if (force_blank) return 24'h0;
        cx = int'(cur_pos[23:12]);
        cy = int'(cur_pos[11:0]);
        if (!cur_off && x >= cx && x < cx + 64 && y >= cy && y < cy + 64) begin
            dx = x - cx;
            dy = y - cy;
            w = m_pat[dy * 8 + dx / 8];
            code = int'((w >> (2 * (dx % 8))) & 16'h3);
            if (code != 0) return m_cpal[code - 1];
        end
        return m_clut[idx];
    endfunction

    task automatic wr(input logic [1:0] s, input int a, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_addr = 9'(a); wr_data = d;
        if (s == 2'd0) m_clut[a % 256] = d;
        if (s == 2'd1 && a < 3) m_cpal[a] = d;
        if (s == 2'd2) m_pat[a] = d[15:0];
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic send(input int x, input int y, input int idx, input string req);
        logic [23:0] exp;
        @(negedge clk);
        in_valid = 1'b1; in_x = 12'(x); in_y = 12'(y); in_index = 8'(idx);
        exp = model(x, y, idx);
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 early valid: actual %b expected 0", out_valid);
        end
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1 || out_x !== 12'(x) || out_y !== 12'(y) || out_rgb !== exp) begin
            errors++;
            $display("FAIL %s (%0d,%0d) idx %0d: actual v=%b x=%0d y=%0d rgb=%h expected v=1 x=%0d y=%0d rgb=%h",
                     req, x, y, idx, out_valid, out_x, out_y, out_rgb, x, y, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        foreach (m_clut[i]) m_clut[i] = '0;
        foreach (m_cpal[i]) m_cpal[i] = '0;
        foreach (m_pat[i])  m_pat[i]  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset valid: actual %b expected 0", out_valid);
        end
        // R1: cleared memories give black, even inside cursor
        cur_pos = {12'd10, 12'd10};
        send(12, 12, 77, "R1");
        send(300, 300, 255, "R1");

        for (int i = 0; i < 256; i++) wr(2'd0, i, 24'($urandom));
        for (int i = 0; i < 3; i++) wr(2'd1, i, 24'($urandom));
        for (int i = 0; i < 512; i++) wr(2'd2, i, {8'h0, 16'($urandom)});

        // R3: outside cursor
        cur_pos = {12'd100, 12'd50};
        send(0, 0, 5, "R3");
        send(99, 50, 200, "R3");
        // R4: corners of the cursor area
        wr(2'd2, 0, 24'h00E4E4);
        wr(2'd2, 511, 24'h00C000);
        send(100, 50, 9, "R4");
        send(163, 113, 9, "R4");
        send(164, 50, 9, "R4");
        send(100, 114, 9, "R4");
        // R5/R6: codes 0..3 in lanes 0..3 of word 0
        send(101, 50, 3, "R6");
        send(102, 50, 3, "R6");
        send(103, 50, 3, "R5");
        wr(2'd2, 8 * 7 + 2, 24'h003000);
        send(100 + 16 + 6, 50 + 7, 1, "R5");
        // R9: clipped at the right edge, no wrap
        wr(2'd2, 1, 24'h00FFFF);
        cur_pos = {12'd4090, 12'd50};
        send(2, 50, 44, "R9");
        send(4095, 50, 44, "R9");
        cur_pos = {12'd100, 12'd4080};
        send(100, 3, 45, "R9");
        // R7: cursor off
        cur_pos = {12'd100, 12'd50};
        cur_off = 1'b1;
        send(101, 50, 6, "R7");
        send(163, 113, 6, "R7");
        cur_off = 1'b0;
        // R8: forced blank
        force_blank = 1'b1;
        send(0, 0, 5, "R8");
        send(101, 50, 6, "R8");
        force_blank = 1'b0;
        // R10: ignored writes (cursor address aliasing and target 3)
        wr(2'd1, 4, 24'hABCDEF);
        wr(2'd1, 7, 24'h123456);
        wr(2'd3, 5, 24'h777777);
        send(101, 50, 5, "R10");
        send(102, 50, 5, "R10");
        send(103, 50, 5, "R10");
        send(0, 0, 5, "R10");
        wr(2'd1, 2, 24'h00FF00);
        send(103, 50, 5, "R10");

        // random mix
        for (int b = 0; b < 20; b++) begin
            cur_pos = {12'($urandom_range(0, 4095)), 12'($urandom_range(0, 4095))};
            cur_off = ($urandom_range(0, 7) == 0);
            force_blank = ($urandom_range(0, 7) == 0);
            if (($urandom & 1) == 1) wr(2'd0, $urandom_range(0, 255), 24'($urandom));
            for (int k = 0; k < 15; k++) begin
                int rx, ry;
                rx = (int'(cur_pos[23:12]) + $urandom_range(0, 96) - 16) & 12'hFFF;
                ry = (int'(cur_pos[11:0]) + $urandom_range(0, 96) - 16) & 12'hFFF;
                send(rx, ry, $urandom_range(0, 255), "R6 random");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule